// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Self-Advancing Compare

This block holds a 64-bit up counter and one 64-bit compare register. A software-visible register file reaches both through 32-bit halves. While the run bit is set, the counter advances by one each clock. Software reloads it by writing the low half and then the high half. The low half waits in a staging register, and the whole 64-bit value is committed in one cycle when the high half is written. Reads return the live count. A reader that needs a consistent pair reads the high half, then the low half, then the high half again, and retries if the two high values differ.

The comparator is a small state machine with three states:
- **CMP_IDLE**: the comparator is off.
- **CMP_ARMED**: the comparator watches for the counter to equal the compare value.
- **CMP_SPENT**: a one-shot match has already fired.

The comparator moves between them as follows:
- CMP_IDLE goes to CMP_ARMED when the enable bit is set.
- CMP_ARMED goes to CMP_IDLE when the enable bit is cleared.
- CMP_ARMED goes to CMP_SPENT on a match with auto-advance off.
- CMP_ARMED stays in CMP_ARMED on a match with auto-advance on. The 32-bit step is then added to the 64-bit compare value, so events repeat with no software work.
- CMP_SPENT goes to CMP_ARMED when either half of the compare value is written.
- CMP_SPENT goes to CMP_IDLE when the enable bit is cleared.

Each match sets a sticky status bit, which software clears by writing 1 to it. The single interrupt line is the status bit gated by the enable bit.

Top module: `timer64`

## Requirements
- R1: Writing word address 0 stores a staged low half. Writing word address 1 loads the counter with {written word, staged low half} at that clock edge. Addresses 0 and 1 read the live low and high halves of the counter.
- R2: While control bit 0 (run) is 1 and no load occurs, the counter adds one per clock and wraps modulo 2^64. While run is 0, the counter holds its value.
- R3: The control word at address 5 holds run (bit 0), compare enable (bit 1) and auto-advance (bit 2), and reads back those bits. With compare enable 0, no match is detected and the status bit is not set.
- R4: With auto-advance off, the comparator fires once and then detects no further match until address 2 or 3 is written while enabled.
- R5: Addresses 2 and 3 write and read the low and high halves of the compare value, and address 4 holds the 32-bit step. With auto-advance on, each match adds the zero-extended step to the 64-bit compare value, with carry into the high half. A compare write in the same cycle takes precedence over the addition.
- R6: Bit 0 of address 7 is the status bit. It becomes 1 at the clock edge that ends a cycle in which the armed comparator sees counter == compare. A clear arriving in that same cycle loses to the set.
- R7: Writing a word with bit 0 = 1 to address 7 clears the status bit. Writing bit 0 = 0 leaves it unchanged.
- R8: Bit 0 of address 6 is the interrupt enable. The `irq` output is 1 exactly when both the status bit and the interrupt enable are 1.
- R9: After reset, every register reads 0 and `irq` is 0.
- R10: Unused bits of the control, enable and status words read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational, no side effects) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` hold defined values whenever reset is released, and that only one register is written per cycle. They also assume that the interrupt can only rise through a match or an enable write, which holds because no other input touches the status or enable bits. The stimulus drives every input to a known value from time zero and changes inputs only on the falling clock edge. A behavioural model follows the same write sequence, and the stimulus times its writes from the model's counter. This lets it place a status clear exactly on the match cycle, and place a counter load across the 32-bit carry boundary.

// File: rtl/timer64_pkg.sv
package timer64_pkg;

    typedef enum logic [2:0] {
        A_CNT_LO  = 3'd0,
        A_CNT_HI  = 3'd1,
        A_CMP_LO  = 3'd2,
        A_CMP_HI  = 3'd3,
        A_STEP    = 3'd4,
        A_CTRL    = 3'd5,
        A_IEN     = 3'd6,
        A_ISTAT   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        CMP_IDLE  = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_SPENT = 2'd2
    } cmp_state_e;

    localparam int BIT_RUN  = 0;
    localparam int BIT_CEN  = 1;
    localparam int BIT_AUTO = 2;

endpackage

// File: rtl/timer64_counter.sv
module timer64_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/timer64_cmp.sv
module timer64_cmp
    import timer64_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic              auto_inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] step,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cmp,
    output logic              match
);

    cmp_state_e state_q, state_d;
    logic       cmp_wr;

    assign cmp_wr = wr_lo || wr_hi;
    assign match  = (state_q == CMP_ARMED) && (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_IDLE: begin
                if (cmp_en) state_d = CMP_ARMED;
            end
            CMP_ARMED: begin
                if (!cmp_en)                 state_d = CMP_IDLE;
                else if (match && !auto_inc) state_d = CMP_SPENT;
            end
            CMP_SPENT: begin
                if (!cmp_en)     state_d = CMP_IDLE;
                else if (cmp_wr) state_d = CMP_ARMED;
            end
            default: state_d = CMP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (cmp_wr) begin
            if (wr_lo) cmp[DATA_W-1:0]     <= wdata;
            if (wr_hi) cmp[CNT_W-1:DATA_W] <= wdata;
        end else if (match && auto_inc) begin
            cmp <= cmp + {{DATA_W{1'b0}}, step};
        end
    end

endmodule

// File: rtl/timer64_regs.sv
module timer64_regs
    import timer64_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              match,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cmp,
    output logic [DATA_W-1:0] rdata,
    output logic              run,
    output logic              cmp_en,
    output logic              auto_inc,
    output logic              load_cnt,
    output logic [CNT_W-1:0]  load_val,
    output logic              wr_cmp_lo,
    output logic              wr_cmp_hi,
    output logic [DATA_W-1:0] step,
    output logic              ie,
    output logic              stat
);

    reg_addr_e         sel;
    logic [DATA_W-1:0] stage;
    logic              clr_stat;

    assign sel       = reg_addr_e'(addr);
    assign load_cnt  = wr_en && (sel == A_CNT_HI);
    assign load_val  = {wdata, stage};
    assign wr_cmp_lo = wr_en && (sel == A_CMP_LO);
    assign wr_cmp_hi = wr_en && (sel == A_CMP_HI);
    assign clr_stat  = wr_en && (sel == A_ISTAT) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage    <= '0;
            step     <= '0;
            run      <= 1'b0;
            cmp_en   <= 1'b0;
            auto_inc <= 1'b0;
            ie       <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                A_CNT_LO: stage <= wdata;
                A_STEP:   step  <= wdata;
                A_CTRL: begin
                    run      <= wdata[BIT_RUN];
                    cmp_en   <= wdata[BIT_CEN];
                    auto_inc <= wdata[BIT_AUTO];
                end
                A_IEN:    ie    <= wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= 1'b0;
        end else if (match) begin
            stat <= 1'b1;
        end else if (clr_stat) begin
            stat <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            A_CNT_LO: rdata = cnt[DATA_W-1:0];
            A_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
            A_CMP_LO: rdata = cmp[DATA_W-1:0];
            A_CMP_HI: rdata = cmp[CNT_W-1:DATA_W];
            A_STEP:   rdata = step;
            A_CTRL: begin
                rdata[BIT_RUN]  = run;
                rdata[BIT_CEN]  = cmp_en;
                rdata[BIT_AUTO] = auto_inc;
            end
            A_IEN:    rdata[0] = ie;
            A_ISTAT:  rdata[0] = stat;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/timer64.sv
module timer64 #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic              run, cmp_en, auto_inc;
    logic              load_cnt, wr_cmp_lo, wr_cmp_hi;
    logic              match, ie, stat;
    logic [CNT_W-1:0]  load_val, cnt, cmp;
    logic [DATA_W-1:0] step;

    timer64_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .match     (match),
        .cnt       (cnt),
        .cmp       (cmp),
        .rdata     (rdata),
        .run       (run),
        .cmp_en    (cmp_en),
        .auto_inc  (auto_inc),
        .load_cnt  (load_cnt),
        .load_val  (load_val),
        .wr_cmp_lo (wr_cmp_lo),
        .wr_cmp_hi (wr_cmp_hi),
        .step      (step),
        .ie        (ie),
        .stat      (stat)
    );

    timer64_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (load_cnt),
        .load_val (load_val),
        .cnt      (cnt)
    );

    timer64_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (cmp_en),
        .auto_inc (auto_inc),
        .wr_lo    (wr_cmp_lo),
        .wr_hi    (wr_cmp_hi),
        .wdata    (wdata),
        .step     (step),
        .cnt      (cnt),
        .cmp      (cmp),
        .match    (match)
    );

    assign irq = stat && ie;

endmodule

// File: rtl/timer64_chk.sv
module timer64_chk #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              run,
    input logic              cmp_en,
    input logic              auto_inc,
    input logic              load_cnt,
    input logic [CNT_W-1:0]  load_val,
    input logic              wr_cmp_lo,
    input logic              wr_cmp_hi,
    input logic [DATA_W-1:0] step,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              match,
    input logic              stat
);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> cnt == $past(load_val)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load_cnt |=> cnt == $past(cnt) + CNT_W'(1)); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load_cnt |=> $stable(cnt)); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> !match); // R3

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        match && !auto_inc && !wr_cmp_lo && !wr_cmp_hi |=> !match); // R4

    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        match && auto_inc && !wr_cmp_lo && !wr_cmp_hi
        |=> cmp == $past(cmp) + {{DATA_W{1'b0}}, $past(step)}); // R5

    AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> stat); // R6

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == 3'd7 && wdata[0] && !match |=> !stat); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(match) || $past(wr_en && addr == 3'd6)); // R8

endmodule

bind timer64 timer64_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/timer64_bench.sv
`timescale 1ns/1ps
module timer64_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    timer64 u_timer64 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    logic [63:0] m_cnt = '0, m_cmp = '0;
    logic [31:0] m_stage = '0, m_step = '0;
    logic        m_run = 0, m_en = 0, m_ai = 0, m_ie = 0, m_st = 0;
    int          m_state = 0;  // 0 off, 1 watching, 2 fired

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '0; m_stage = '0; m_step = '0;
            m_run = 0; m_en = 0; m_ai = 0; m_ie = 0; m_st = 0; m_state = 0;
        end else begin
            bit hit, cw;
            hit = (m_state == 1) && (m_cnt == m_cmp);
            cw  = wr_en && (addr == 3'd2 || addr == 3'd3);
            case (m_state)
                0: if (m_en) m_state = 1;
                1: if (!m_en) m_state = 0; else if (hit && !m_ai) m_state = 2;
                default: if (!m_en) m_state = 0; else if (cw) m_state = 1;
            endcase
            if (wr_en && addr == 3'd1) m_cnt = {wdata, m_stage};
            else if (m_run)            m_cnt = m_cnt + 64'd1;
            if (cw) begin
                if (addr == 3'd2) m_cmp[31:0]  = wdata;
                else              m_cmp[63:32] = wdata;
            end else if (hit && m_ai) begin
                m_cmp = m_cmp + {32'd0, m_step};
            end
            if (hit) m_st = 1;
            else if (wr_en && addr == 3'd7 && wdata[0]) m_st = 0;
            if (wr_en) begin
                case (addr)
                    3'd0: m_stage = wdata;
                    3'd4: m_step = wdata;
                    3'd5: begin m_run = wdata[0]; m_en = wdata[1]; m_ai = wdata[2]; end
                    3'd6: m_ie = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt[31:0];
            3'd1: return m_cnt[63:32];
            3'd2: return m_cmp[31:0];
            3'd3: return m_cmp[63:32];
            3'd4: return m_step;
            3'd5: return {29'd0, m_ai, m_en, m_run};
            3'd6: return {31'd0, m_ie};
            default: return {31'd0, m_st};
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R1";
            3'd2, 3'd3, 3'd4: return "R5";
            3'd5: return "R3";
            3'd6: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(irq == (m_st && m_ie), "R8", 64'(irq), 64'(m_st && m_ie));
            check(rdata == m_rd(addr), tag_of(addr), 64'(rdata), 64'(m_rd(addr)));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL R9 watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(rdata == exp, req, 64'(rdata), 64'(exp));
    endtask

    initial begin
        logic [31:0] snap;
        logic [63:0] tgt;
        repeat (4) @(negedge clk);
        // R9: reset state
        for (int a = 0; a < 8; a++) begin
            addr = a[2:0]; #1;
            check(rdata == 32'd0, "R9", 64'(rdata), 64'd0);
        end
        check(irq == 1'b0, "R9", 64'(irq), 64'd0);
        rst_n = 1;

        // R1 staged load across carry boundary, R2 carry into high half
        wr(3'd0, 32'hFFFF_FFF0);
        rd_chk(3'd0, 32'd0, "R1");
        wr(3'd1, 32'h0000_0001);
        rd_chk(3'd1, 32'h1, "R1");
        rd_chk(3'd0, 32'hFFFF_FFF0, "R1");
        wr(3'd5, 32'h1);
        repeat (30) @(negedge clk);
        rd_chk(3'd1, 32'h2, "R2");
        // R10: unused bits read zero
        wr(3'd6, 32'hFFFF_FFFF);
        rd_chk(3'd6, 32'h1, "R10");
        wr(3'd5, 32'hFFFF_FFF8);
        rd_chk(3'd5, 32'h0, "R10");
        // R2 hold while stopped
        rd_chk(3'd0, m_cnt[31:0], "R2");
        snap = rdata;
        repeat (10) @(negedge clk);
        rd_chk(3'd0, snap, "R2");

        // R3: compare disabled -> no status
        wr(3'd0, 32'h100); wr(3'd1, 32'h0);
        wr(3'd2, 32'h110); wr(3'd3, 32'h0);
        wr(3'd5, 32'h5);
        repeat (40) @(negedge clk);
        rd_chk(3'd7, 32'h0, "R3");
        rd_chk(3'd5, 32'h5, "R3");

        // R6: clear on the match cycle loses to the set
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h200); wr(3'd1, 32'h0);
        wr(3'd2, 32'h240); wr(3'd3, 32'h0);
        wr(3'd5, 32'h3);
        tgt = 64'h240;
        forever begin
            @(negedge clk);
            if (m_cnt == tgt) break;
        end
        wr_en = 1; addr = 3'd7; wdata = 32'h1;
        @(negedge clk);
        wr_en = 0;
        rd_chk(3'd7, 32'h1, "R6");
        check(irq == 1'b1, "R8", 64'(irq), 64'd1);
        // R7: writing 0 keeps, writing 1 clears
        wr(3'd7, 32'h0);
        rd_chk(3'd7, 32'h1, "R7");
        wr(3'd7, 32'h1);
        rd_chk(3'd7, 32'h0, "R7");
        check(irq == 1'b0, "R8", 64'(irq), 64'd0);
        // R4: no refire, then re-arm by compare write
        repeat (40) @(negedge clk);
        rd_chk(3'd7, 32'h0, "R4");
        wr(3'd2, m_cnt[31:0] + 32'd20);
        repeat (40) @(negedge clk);
        rd_chk(3'd7, 32'h1, "R4");
        wr(3'd7, 32'h1);
        wr(3'd6, 32'h0);
        rd_chk(3'd6, 32'h0, "R8");

        // R5: auto-advance with carry into compare high half
        wr(3'd5, 32'h0);
        wr(3'd7, 32'h1);
        wr(3'd0, 32'hFFFF_FFE0); wr(3'd1, 32'h1);
        wr(3'd2, 32'hFFFF_FFF0); wr(3'd3, 32'h1);
        wr(3'd4, 32'h20);
        wr(3'd6, 32'h1);
        wr(3'd5, 32'h7);
        repeat (25) @(negedge clk);
        rd_chk(3'd3, 32'h2, "R5");
        rd_chk(3'd2, 32'h10, "R5");
        rd_chk(3'd7, 32'h1, "R6");
        wr(3'd7, 32'h1);
        repeat (200) @(negedge clk);
        rd_chk(3'd7, 32'h1, "R5");
        wr(3'd5, 32'h0);
        repeat (5) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule